// File: doc/BRIEF.md
# Strobe-Bus Serial Nonvolatile Memory Controller

This block is the device-side control logic for a 512-byte nonvolatile memory. The memory is reached over a processor-style strobe bus: an active-low chip select, an active-low read strobe and an active-low write strobe. All data, addresses and commands move one bit at a time over a single data line. Each bus access is classified as a read or a write cycle. Commands are formed from short read/write/read patterns. In each pattern, the bit carried by the middle write selects either a sequence reset or the start of a page commit.

After a reset pattern, the host shifts in a 16-bit address. Only the low 9 bits of that address are kept. The host then either reads bytes sequentially, one bit per read cycle, or loads up to a page of 8 bytes. A loaded page is committed into the register-array memory by a timed operation that lasts a parameterized number of clocks. During that time, every read returns a busy indication. A write-enable latch and a protect input guard the commit.

Top module: `serbus_nvm_ctrl`

## Requirements
- R1: A write cycle is chip select low and write strobe low with read strobe high. A read cycle is chip select low and read strobe low with write strobe high. A write carries the data-in level last seen before the cycle ends.
- R2: A read cycle followed by a write of 0 resets the sequence. It aborts a sequential read or a page load and sets the write-enable latch. The next read returns 1. During a commit, writes are ignored.
- R3: After a reset, 16 consecutive write cycles form the address, most significant bit first. Only the last 9 bits are kept as the byte address.
- R4: After the address, read cycles return bytes most significant bit first. The byte address advances after every 8th read and wraps from 0x1FF to 0x000.
- R5: After power-up, and after a reset until an address has been completed, read cycles return 1.
- R6: Writes after the address fill the 8-byte page whose base has the low 3 address bits cleared. The fill starts at the addressed byte and wraps within the page, so later bytes overwrite earlier ones.
- R7: A read, then a write of 1, then a read, issued right after a page load, starts the commit. No commit starts if the load ended on a partial byte.
- R8: The write-enable latch is clear after power-up and after every commit, and it is held clear while the protect input is low. Lowering the protect input during a commit does not abort that commit.
- R9: While a commit runs, every read cycle returns 0, including the reads of a reset pattern. Once the commit ends, reads return 1.
- R10: The data output enable is high exactly when chip select and read strobe are both low at the pins.
- R11: A cycle with both strobes low is ignored and does not disturb a sequence in progress.
- R12: A commit lasts COMMIT_CYCLES clocks from the end of its final read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| prog_allow | input | 1 | High permits commits; low clears the write-enable latch |
| sdata_in | input | 1 | Serial data bit from the host |
| sdata_out | output | 1 | Serial data bit to the host |
| sdata_drv | output | 1 | Output enable for the data pin |

## Verification
The bench exercises commits of full pages, loads that start in mid-page and overflow the page, and loads that end on a partial byte. It also covers commits attempted with protect low and commits during which protect falls. Each of these tells apart whether the page wrap, the completeness gate and the latch gate act at the right moment. Sequential reads are run across the top of the address space to separate the rollover from a plain increment. Reset patterns are issued in the middle of a read stream and again during a commit, which shows whether a reset aborts the stream but leaves the busy status alone. Finally, a conflicting cycle is inserted in a read stream; if it were treated as a write of 0 it would cause a reset, and the bench would see the wrong data.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RSTRD,
      ST_ADDR,
      ST_SEQ,
      ST_READ,
      ST_LOAD,
      ST_LDEND,
      ST_GO,
      ST_BUSY
   } seq_state_t;
endpackage

// File: rtl/sbn_sync.sv
module sbn_sync #(
   parameter int          W       = 5,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= RST_VAL[i];
            sync_q <= RST_VAL[i];
         end else begin
            meta_q <= din[i];
            sync_q <= meta_q;
         end
      end
      assign dout[i] = sync_q;
   end
endmodule

// File: rtl/sbn_cycle_det.sv
module sbn_cycle_det (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic din,
   output logic wr_end,
   output logic wr_bit,
   output logic rd_end
);
   logic wr_act, rd_act, wr_q, rd_q, bit_q;

   assign wr_act = !cs_n && !wr_n && rd_n;
   assign rd_act = !cs_n && !rd_n && wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= 1'b0;
         rd_q  <= 1'b0;
         bit_q <= 1'b0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act) bit_q <= din;
      end
   end

   assign wr_end = wr_q && !wr_act;
   assign rd_end = rd_q && !rd_act;
   assign wr_bit = bit_q;

   logic conflict;
   assign conflict = !cs_n && !rd_n && !wr_n;

   AST_CONFLICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      conflict && $past(conflict) |-> !wr_end && !rd_end); // R11
endmodule

// File: rtl/sbn_store.sv
module sbn_store #(
   parameter int DEPTH         = 512,
   parameter int PAGE_BYTES    = 8,
   parameter int COMMIT_CYCLES = 5000,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = $clog2(PAGE_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_start,
   input  logic [PW-1:0]   ld_col,
   input  logic [AW-PW-1:0] ld_base,
   input  logic            ld_vld,
   input  logic            ld_bit,
   input  logic            commit_req,
   input  logic [AW-1:0]   rd_addr,
   output logic [7:0]      rd_data,
   output logic            busy,
   output logic            ld_ok,
   output logic            commit_done
);
   localparam int TW = $clog2(COMMIT_CYCLES + 1);

   if (COMMIT_CYCLES < 1) begin : g_bad_commit
      $error("COMMIT_CYCLES must be at least 1");
   end

   logic [7:0]            mem    [DEPTH];
   logic [7:0]            page_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask_q;
   logic [PW-1:0]         col_q;
   logic [2:0]            bcnt_q;
   logic [6:0]            sh_q;
   logic [AW-PW-1:0]      base_q;
   logic [TW-1:0]         timer_q;
   logic                  busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         col_q   <= '0;
         bcnt_q  <= '0;
         sh_q    <= '0;
         base_q  <= '0;
         timer_q <= '0;
         busy_q  <= 1'b0;
      end else begin
         if (ld_start) begin
            mask_q <= '0;
            col_q  <= ld_col;
            base_q <= ld_base;
            bcnt_q <= '0;
         end else if (ld_vld) begin
            sh_q   <= {sh_q[5:0], ld_bit};
            bcnt_q <= bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) begin
               mask_q[col_q] <= 1'b1;
               col_q         <= col_q + 1'b1;
            end
         end
         if (busy_q) begin
            if (timer_q == '0) busy_q <= 1'b0;
            else               timer_q <= timer_q - 1'b1;
         end else if (commit_req) begin
            busy_q  <= 1'b1;
            timer_q <= TW'(COMMIT_CYCLES - 1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!ld_start && ld_vld && bcnt_q == 3'd7) page_q[col_q] <= {sh_q, ld_bit};
   end

   assign commit_done = busy_q && (timer_q == '0);

   always_ff @(posedge clk) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
         if (commit_done && mask_q[j]) mem[{base_q, PW'(j)}] <= page_q[j];
      end
   end

   assign rd_data = mem[rd_addr];
   assign busy    = busy_q;
   assign ld_ok   = (bcnt_q == 3'd0) && (mask_q != '0);

   AST_COMMIT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(ld_ok)); // R7
endmodule

// File: rtl/serbus_nvm_ctrl.sv
module serbus_nvm_ctrl
   import sbn_pkg::*;
#(
   parameter int DEPTH         = 512,
   parameter int PAGE_BYTES    = 8,
   parameter int ADDR_BITS     = 16,
   parameter int COMMIT_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_cs_n,
   input  logic bus_rd_n,
   input  logic bus_wr_n,
   input  logic prog_allow,
   input  logic sdata_in,
   output logic sdata_out,
   output logic sdata_drv
);
   localparam int AW  = $clog2(DEPTH);
   localparam int PW  = $clog2(PAGE_BYTES);
   localparam int ACW = $clog2(ADDR_BITS);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 || PAGE_BYTES > DEPTH) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and DEPTH");
   end
   if (ADDR_BITS < AW) begin : g_bad_abits
      $error("ADDR_BITS must cover the byte address");
   end

   logic [4:0] s_vec;
   logic s_cs, s_rd, s_wr, s_din, s_allow;

   sbn_sync #(.W(5), .RST_VAL(5'b11111)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({prog_allow, sdata_in, bus_wr_n, bus_rd_n, bus_cs_n}),
      .dout (s_vec)
   );
   assign {s_allow, s_din, s_wr, s_rd, s_cs} = s_vec;

   logic wr_end, wbit, rd_end;

   sbn_cycle_det u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (s_cs),
      .rd_n  (s_rd),
      .wr_n  (s_wr),
      .din   (s_din),
      .wr_end(wr_end),
      .wr_bit(wbit),
      .rd_end(rd_end)
   );

   seq_state_t     st, st_n;
   logic           prev_rd, wel;
   logic [ACW-1:0] acnt, acnt_n;
   logic [AW-1:0]  addr_q, addr_n;
   logic [2:0]     rbit, rbit_n;
   logic           rst_evt, ld_vld, ld_start, commit_go;
   logic [7:0]     rd_data;
   logic           busy_w, ld_ok, done_w;

   always_comb begin
      st_n      = st;
      acnt_n    = acnt;
      addr_n    = addr_q;
      rbit_n    = rbit;
      rst_evt   = 1'b0;
      ld_vld    = 1'b0;
      ld_start  = 1'b0;
      commit_go = 1'b0;
      if (st == ST_BUSY) begin
         if (done_w) st_n = ST_IDLE;
      end else if (wr_end) begin
         if (st == ST_ADDR) begin
            addr_n = {addr_q[AW-2:0], wbit};
            acnt_n = acnt + 1'b1;
            if (acnt == ACW'(ADDR_BITS - 1)) begin
               st_n     = ST_SEQ;
               rbit_n   = '0;
               ld_start = 1'b1;
            end
         end else if (prev_rd && !wbit) begin
            rst_evt = 1'b1;
            st_n    = ST_RSTRD;
         end else if (prev_rd && wbit && st == ST_LDEND) begin
            st_n = ST_GO;
         end else if (st == ST_SEQ || st == ST_LOAD) begin
            ld_vld = 1'b1;
            st_n   = ST_LOAD;
         end else begin
            st_n = ST_IDLE;
         end
      end else if (rd_end) begin
         case (st)
            ST_RSTRD: begin
               st_n   = ST_ADDR;
               acnt_n = '0;
            end
            ST_SEQ, ST_READ: begin
               st_n   = ST_READ;
               rbit_n = rbit + 3'd1;
               if (rbit == 3'd7) addr_n = addr_q + 1'b1;
            end
            ST_LOAD: st_n = ST_LDEND;
            ST_GO: begin
               if (wel && s_allow && ld_ok) begin
                  commit_go = 1'b1;
                  st_n      = ST_BUSY;
               end else begin
                  st_n = ST_IDLE;
               end
            end
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         prev_rd <= 1'b0;
         acnt    <= '0;
         addr_q  <= '0;
         rbit    <= '0;
         wel     <= 1'b0;
      end else begin
         st     <= st_n;
         acnt   <= acnt_n;
         addr_q <= addr_n;
         rbit   <= rbit_n;
         if (wr_end)      prev_rd <= 1'b0;
         else if (rd_end) prev_rd <= 1'b1;
         if (!s_allow || done_w) wel <= 1'b0;
         else if (rst_evt)       wel <= 1'b1;
      end
   end

   sbn_store #(
      .DEPTH        (DEPTH),
      .PAGE_BYTES   (PAGE_BYTES),
      .COMMIT_CYCLES(COMMIT_CYCLES)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_start   (ld_start),
      .ld_col     (addr_n[PW-1:0]),
      .ld_base    (addr_n[AW-1:PW]),
      .ld_vld     (ld_vld),
      .ld_bit     (wbit),
      .commit_req (commit_go),
      .rd_addr    (addr_q),
      .rd_data    (rd_data),
      .busy       (busy_w),
      .ld_ok      (ld_ok),
      .commit_done(done_w)
   );

   always_comb begin
      case (st)
         ST_BUSY:         sdata_out = 1'b0;
         ST_SEQ, ST_READ: sdata_out = rd_data[3'd7 - rbit];
         default:         sdata_out = 1'b1;
      endcase
   end

   assign sdata_drv = !bus_cs_n && !bus_rd_n;

   AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w && sdata_drv |-> !sdata_out); // R9
   AST_ADDR_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end && (st == ST_READ || st == ST_SEQ) && rbit == 3'd7 && addr_q == {AW{1'b1}}
      |=> addr_q == '0); // R4
   AST_PROT_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !s_allow |=> !wel); // R8
   AST_BUSY_IGNORES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w && !done_w && wr_end |=> $stable(addr_q) && st == ST_BUSY); // R2
endmodule

// File: tb/serbus_nvm_ctrl_test.sv
module serbus_nvm_ctrl_test;
   localparam int CC = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, allow = 1'b1, din = 1'b0;
   logic dout, drv;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int mem_m [512];
   int pg [8];
   bit pm [8];

   always #10 clk = ~clk;

   serbus_nvm_ctrl #(.COMMIT_CYCLES(CC)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_cs_n  (cs_n),
      .bus_rd_n  (rd_n),
      .bus_wr_n  (wr_n),
      .prog_allow(allow),
      .sdata_in  (din),
      .sdata_out (dout),
      .sdata_drv (drv)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // R10: output enable compared against the pins on every clock
   always @(negedge clk) begin
      if (rst_n && !finished) chk(drv === (!cs_n && !rd_n), "R10 drive enable", int'(drv), int'(!cs_n && !rd_n));
   end

   task automatic bw(input logic b);
      din = b; cs_n = 1'b0; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic br(output logic v);
      cs_n = 1'b0; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      v = dout;
      cs_n = 1'b1; rd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic reset_seq();
      logic v;
      br(v); bw(1'b0); br(v);
   endtask

   // R3: 16 address bits, upper 7 sent as ones to show they are discarded
   task automatic send_addr(input int a);
      for (int i = 15; i >= 0; i--) bw(i >= 9 ? 1'b1 : a[i]);
   endtask

   task automatic load_and_commit(input int a, input int nbytes, input int seed,
                                  input int extra_bits, input bit model_commit);
      logic v;
      int col, base, b;
      reset_seq();
      send_addr(a);
      for (int j = 0; j < 8; j++) pm[j] = 0;
      col = a % 8; base = a - (a % 8);
      for (int k = 0; k < nbytes; k++) begin
         b = (seed + k * 37) & 255;
         for (int i = 7; i >= 0; i--) bw(b[i]);
         pg[col] = b; pm[col] = 1; col = (col + 1) % 8;
      end
      for (int i = 0; i < extra_bits; i++) bw(1'b1);
      br(v); bw(1'b1); br(v);
      if (model_commit) for (int j = 0; j < 8; j++) if (pm[j]) mem_m[base + j] = pg[j];
   endtask

   task automatic wait_done(input string tag);
      logic v;
      int polls;
      polls = 1;
      v = 1'b0;
      while (polls < 200 && v !== 1'b1) begin
         br(v);
         polls++;
      end
      chk(v === 1'b1, tag, int'(v), 1);
      chk(polls >= CC / 8 - 3 && polls <= CC / 8 + 3, "R12 commit length in polls", polls, CC / 8);
   endtask

   task automatic read_check(input int a, input int n, input string tag);
      logic v;
      logic [7:0] got;
      reset_seq();
      send_addr(a);
      for (int k = 0; k < n; k++) begin
         for (int i = 7; i >= 0; i--) begin br(v); got[i] = v; end
         chk(int'(got) == mem_m[(a + k) % 512], tag, int'(got), mem_m[(a + k) % 512]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic v;
      logic [7:0] got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R10 / R5: reset state
      chk(drv == 1'b0, "R10 idle drive", int'(drv), 0);
      br(v); chk(v == 1'b1, "R5 read before any address", int'(v), 1);

      // R1 R3 R6 R7 R9: full page at 0x010
      load_and_commit(32'h010, 8, 8'h11, 0, 1);
      br(v); chk(v == 1'b0, "R9 busy reads 0", int'(v), 0);
      wait_done("R9 status 1 after commit");
      read_check(32'h010, 8, "R4 sequential readback");

      // R6: start mid-page, overflow wraps inside the page
      load_and_commit(32'h018, 8, 8'h40, 0, 1);
      wait_done("R9 done");
      load_and_commit(32'h01E, 10, 8'h93, 0, 1);
      wait_done("R9 done");
      read_check(32'h018, 8, "R6 page wrap");

      // R4: rollover at the top of the array
      load_and_commit(32'h1F8, 8, 8'h27, 0, 1);
      wait_done("R9 done");
      load_and_commit(32'h000, 8, 8'hC5, 0, 1);
      wait_done("R9 done");
      read_check(32'h1FE, 4, "R4 rollover");

      // R7: partial byte blocks commit
      load_and_commit(32'h040, 8, 8'h5A, 0, 1);
      wait_done("R9 done");
      load_and_commit(32'h040, 3, 8'h0F, 3, 0);
      br(v); chk(v == 1'b1, "R7 partial load not busy", int'(v), 1);
      read_check(32'h040, 8, "R7 partial load left memory");

      // R8: protect low blocks commit
      allow = 1'b0;
      load_and_commit(32'h040, 8, 8'hE1, 0, 0);
      br(v); chk(v == 1'b1, "R8 protected not busy", int'(v), 1);
      allow = 1'b1;
      read_check(32'h040, 8, "R8 protected memory unchanged");

      // R8: protect dropped during commit does not abort it
      load_and_commit(32'h080, 8, 8'h66, 0, 1);
      br(v); chk(v == 1'b0, "R8 commit running", int'(v), 0);
      allow = 1'b0;
      wait_done("R8 commit finished under protect");
      allow = 1'b1;
      read_check(32'h080, 8, "R8 commit kept");

      // R2 R9: reset pattern during commit keeps busy status
      load_and_commit(32'h0C0, 8, 8'hB2, 0, 1);
      br(v); chk(v == 1'b0, "R9 busy", int'(v), 0);
      bw(1'b0);
      br(v); chk(v == 1'b0, "R2 reset ignored while committing", int'(v), 0);
      wait_done("R9 done after reset");
      read_check(32'h0C0, 8, "R9 readback");

      // R2 R5: reset aborts a sequential read
      reset_seq();
      send_addr(32'h010);
      br(v); br(v); br(v);
      chk(v == mem_m[16'h010][5], "R4 third bit", int'(v), int'(mem_m[16'h010][5]));
      bw(1'b0);
      br(v); chk(v == 1'b1, "R2 reset aborts read", int'(v), 1);
      br(v); chk(v == 1'b1, "R5 no address yet", int'(v), 1);

      // R11: conflicting cycle inside a read stream
      reset_seq();
      send_addr(32'h018);
      for (int i = 7; i >= 5; i--) begin br(v); got[i] = v; end
      din = 1'b0; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 4; i >= 0; i--) begin br(v); got[i] = v; end
      chk(int'(got) == mem_m[16'h018], "R11 conflict ignored", int'(got), mem_m[16'h018]);
      for (int i = 7; i >= 0; i--) begin br(v); got[i] = v; end
      chk(int'(got) == mem_m[16'h019], "R11 stream continues", int'(got), mem_m[16'h019]);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule